// File: doc/BRIEF.md
# Secure Two-Way Doorbell Mailbox

This block carries doorbell notifications between an application processor and a system control processor. Each side has its own simple register port, with valid, write, address and data signals, a read-data return and a security attribute. Behind the two ports sit two secure channels, one for each direction. Each channel has a status word and two write-only views of it: a set view, where every 1 written sets that status bit, and a clear view, where every 1 written clears it. A sender rings a slot by setting its bit. The receiver sees a level interrupt and acknowledges by clearing the bit. The sender must read the bit as 0 before it uses that slot again.

The most significant status bit is not a doorbell slot. The hardware raises it when a non-secure access reaches a register of that channel, which leaves 31 usable slots (0 to 30) per channel. A non-secure access has no effect on the slot bits and reads as zero. Its only effect is to set that flag bit. The flag bit stays set until a secure write to the clear view clears it.

Top module: `sec_doorbell_mbox`

## Requirements
- R1: After reset both status words read 0 and both interrupt outputs are low.
- R2: A secure write to a set view (0x208 for the channel toward the control processor, 0x308 for the channel toward the application processor) sets each status bit in 30:0 that is 1 in the data. All other bits keep their value.
- R3: A secure write to a clear view (0x210 and 0x310) clears each status bit that is 1 in the data. All other bits keep their value.
- R4: `irqToCtl` is high exactly while the status word at 0x200 is nonzero, and `irqToApp` is high exactly while the status word at 0x300 is nonzero. Both follow the status in the cycle after the write.
- R5: Bit 31 of a set-view write has no effect on status bit 31.
- R6: A non-secure read or write of any of a channel's three registers reads 0 and leaves slots 30:0 unchanged. It sets bit 31 of that channel's status word.
- R7: Status bit 31 clears only when a secure write to the clear view has bit 31 at 1. A clear of bits 30:0 leaves it set.
- R8: Reads of the set views, the clear views and unmapped offsets return 0. Writes to a status word or to an unmapped offset change nothing.
- R9: If one port sets a bit and the other port clears the same bit of the same channel in one cycle, the bit ends up set.
- R10: Either port can reach both channels. Set writes from both ports in one cycle to the same channel both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| appValid | input | 1 | Application-side access strobe |
| appWrite | input | 1 | Application-side write (1) or read (0) |
| appSecure | input | 1 | Application-side access is secure |
| appAddr | input | ADDR_W | Application-side byte offset |
| appWdata | input | DATA_W | Application-side write data |
| appRdata | output | DATA_W | Application-side read data, valid in the same cycle |
| ctlValid | input | 1 | Control-side access strobe |
| ctlWrite | input | 1 | Control-side write (1) or read (0) |
| ctlSecure | input | 1 | Control-side access is secure |
| ctlAddr | input | ADDR_W | Control-side byte offset |
| ctlWdata | input | DATA_W | Control-side write data |
| ctlRdata | output | DATA_W | Control-side read data, valid in the same cycle |
| irqToCtl | output | 1 | Level interrupt toward the control processor |
| irqToApp | output | 1 | Level interrupt toward the application processor |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 12-bit offset and channel bases at 0x200 and 0x300. This puts the top slot (bit 30) and the flag bit (bit 31) within reach, so all-ones writes show where the slot range ends. With two independent ports, the bench can also drive a set and a clear of the same bit in the same cycle, and two sets to the same channel in the same cycle.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int NCH   = 2;  // channel 0: toward control side, channel 1: toward application side
  localparam int NPORT = 2;  // port 0: application side, port 1: control side

  typedef struct packed {
    logic [NCH-1:0] setEn;
    logic [NCH-1:0] clrEn;
    logic [NCH-1:0] nsHit;
    logic [NCH-1:0] rdStat;
  } dbStrobe_t;
endpackage

// File: rtl/dbmb_decode.sv
module dbmb_decode
  import dbmb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CH0_BASE = 'h200,
  parameter int unsigned CH1_BASE = 'h300,
  parameter int unsigned OFF_SET  = 'h8,
  parameter int unsigned OFF_CLR  = 'h10
) (
  input  logic              valid,
  input  logic              write,
  input  logic              secure,
  input  logic [ADDR_W-1:0] addr,
  output dbStrobe_t         strobe
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = (c == 0) ? CH0_BASE : CH1_BASE;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE + OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + OFF_CLR);

    logic hitStat, hitSet, hitClr, hitAny;
    assign hitStat = (addr == A_STAT);
    assign hitSet  = (addr == A_SET);
    assign hitClr  = (addr == A_CLR);
    assign hitAny  = hitStat | hitSet | hitClr;

    assign strobe.setEn[c]  = valid &  write &  secure & hitSet;
    assign strobe.clrEn[c]  = valid &  write &  secure & hitClr;
    assign strobe.nsHit[c]  = valid & ~secure & hitAny;
    assign strobe.rdStat[c] = valid & ~write &  secure & hitStat;
  end
endmodule

// File: rtl/dbmb_status.sv
module dbmb_status
  import dbmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dbStrobe_t [NPORT-1:0]        strobe,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [NPORT-1:0][DATA_W-1:0] rdata,
  output logic [NCH-1:0]               chBusy
);
  localparam int unsigned FLAG = DATA_W - 1;

  logic [NCH-1:0][DATA_W-1:0] status;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] setMask, clrMask, nextStat;
    logic nsFlag;

    always_comb begin
      setMask = '0;
      clrMask = '0;
      nsFlag  = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
        if (strobe[p].setEn[c]) setMask[FLAG-1:0] = setMask[FLAG-1:0] | wdata[p][FLAG-1:0];
        if (strobe[p].clrEn[c]) clrMask = clrMask | wdata[p];
        if (strobe[p].nsHit[c]) nsFlag = 1'b1;
      end
      setMask[FLAG] = nsFlag;
      nextStat = (status[c] & ~clrMask) | setMask;
    end

    always_ff @(posedge clk) begin
      if (!rstN) status[c] <= '0;
      else       status[c] <= nextStat;
    end

    assign chBusy[c] = |status[c];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_comb begin
      rdata[p] = '0;
      for (int c = 0; c < NCH; c++)
        if (strobe[p].rdStat[c]) rdata[p] = rdata[p] | status[c];
    end
  end
endmodule

// File: rtl/sec_doorbell_mbox.sv
module sec_doorbell_mbox
  import dbmb_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CH0_BASE = 'h200,
  parameter int unsigned CH1_BASE = 'h300,
  parameter int unsigned OFF_SET  = 'h8,
  parameter int unsigned OFF_CLR  = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              appValid,
  input  logic              appWrite,
  input  logic              appSecure,
  input  logic [ADDR_W-1:0] appAddr,
  input  logic [DATA_W-1:0] appWdata,
  output logic [DATA_W-1:0] appRdata,
  input  logic              ctlValid,
  input  logic              ctlWrite,
  input  logic              ctlSecure,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [DATA_W-1:0] ctlWdata,
  output logic [DATA_W-1:0] ctlRdata,
  output logic              irqToCtl,
  output logic              irqToApp
);
  logic [NPORT-1:0]              pValid, pWrite, pSecure;
  logic [NPORT-1:0][ADDR_W-1:0]  pAddr;
  logic [NPORT-1:0][DATA_W-1:0]  pWdata, pRdata;
  dbStrobe_t [NPORT-1:0]         strobe;
  logic [NCH-1:0]                chBusy;

  assign pValid  = {ctlValid, appValid};
  assign pWrite  = {ctlWrite, appWrite};
  assign pSecure = {ctlSecure, appSecure};
  assign pAddr   = {ctlAddr, appAddr};
  assign pWdata  = {ctlWdata, appWdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dbmb_decode #(
      .ADDR_W(ADDR_W), .CH0_BASE(CH0_BASE), .CH1_BASE(CH1_BASE),
      .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR)
    ) u_dec (
      .valid(pValid[p]), .write(pWrite[p]), .secure(pSecure[p]),
      .addr(pAddr[p]), .strobe(strobe[p])
    );
  end

  dbmb_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(pWdata),
    .rdata(pRdata), .chBusy(chBusy)
  );

  assign appRdata = pRdata[0];
  assign ctlRdata = pRdata[1];
  assign irqToCtl = chBusy[0];
  assign irqToApp = chBusy[1];
endmodule

// File: rtl/dbmb_checker.sv
module dbmb_checker #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CH0_BASE = 'h200,
  parameter int unsigned CH1_BASE = 'h300,
  parameter int unsigned OFF_SET  = 'h8,
  parameter int unsigned OFF_CLR  = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              appValid,
  input logic              appWrite,
  input logic              appSecure,
  input logic [ADDR_W-1:0] appAddr,
  input logic [DATA_W-1:0] appWdata,
  input logic [DATA_W-1:0] appRdata,
  input logic              ctlValid,
  input logic              ctlWrite,
  input logic              ctlSecure,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic [DATA_W-1:0] ctlWdata,
  input logic [DATA_W-1:0] ctlRdata,
  input logic              irqToCtl,
  input logic              irqToApp
);
  localparam logic [ADDR_W-1:0] S0 = ADDR_W'(CH0_BASE + OFF_SET);
  localparam logic [ADDR_W-1:0] C0 = ADDR_W'(CH0_BASE + OFF_CLR);
  localparam logic [ADDR_W-1:0] T1 = ADDR_W'(CH1_BASE);
  localparam logic [ADDR_W-1:0] S1 = ADDR_W'(CH1_BASE + OFF_SET);
  localparam logic [ADDR_W-1:0] C1 = ADDR_W'(CH1_BASE + OFF_CLR);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!irqToCtl && !irqToApp)); // R1

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (appValid && appWrite && appSecure && appAddr == S0 && |appWdata[DATA_W-2:0]) |=> irqToCtl); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!appValid && !ctlValid) |=> ($stable(irqToCtl) && $stable(irqToApp))); // R4

  AST_NS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (appValid && !appWrite && !appSecure) |-> (appRdata == '0)); // R6

  AST_NS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlValid && !ctlSecure && (ctlAddr == T1 || ctlAddr == S1 || ctlAddr == C1)) |=> irqToApp); // R6

  AST_VIEW_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctlValid && !ctlWrite && (ctlAddr == S0 || ctlAddr == C0 || ctlAddr == S1 || ctlAddr == C1))
    |-> (ctlRdata == '0)); // R8
endmodule

bind sec_doorbell_mbox dbmb_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH0_BASE(CH0_BASE), .CH1_BASE(CH1_BASE),
  .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR)
) u_chk (.*);

// File: tb/sim_sec_doorbell_mbox.sv
module sim_sec_doorbell_mbox;
  localparam int PERIOD = 10;
  localparam logic [11:0] T0 = 12'h200, S0 = 12'h208, C0 = 12'h210;
  localparam logic [11:0] T1 = 12'h300, S1 = 12'h308, C1 = 12'h310;

  logic clk = 1'b0, rstN = 1'b0;
  logic appValid = 0, appWrite = 0, appSecure = 0, ctlValid = 0, ctlWrite = 0, ctlSecure = 0;
  logic [11:0] appAddr = '0, ctlAddr = '0;
  logic [31:0] appWdata = '0, ctlWdata = '0, appRdata, ctlRdata;
  logic irqToCtl, irqToApp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sec_doorbell_mbox u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write on port 0 (app) or 1 (ctl); status visible after the next edge
  task automatic wr(input int port, input bit sec, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    if (port == 0) begin appValid = 1; appWrite = 1; appSecure = sec; appAddr = a; appWdata = d; end
    else begin ctlValid = 1; ctlWrite = 1; ctlSecure = sec; ctlAddr = a; ctlWdata = d; end
    @(negedge clk);
    appValid = 0; ctlValid = 0;
  endtask

  task automatic rd(input int port, input bit sec, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    if (port == 0) begin appValid = 1; appWrite = 0; appSecure = sec; appAddr = a; end
    else begin ctlValid = 1; ctlWrite = 0; ctlSecure = sec; ctlAddr = a; end
    #1;
    d = (port == 0) ? appRdata : ctlRdata;
    if (!sec) begin @(negedge clk); end
    appValid = 0; ctlValid = 0;
  endtask

  task automatic both(input logic [11:0] aA, input logic [31:0] dA, input logic [11:0] aC, input logic [31:0] dC);
    @(negedge clk);
    appValid = 1; appWrite = 1; appSecure = 1; appAddr = aA; appWdata = dA;
    ctlValid = 1; ctlWrite = 1; ctlSecure = 1; ctlAddr = aC; ctlWdata = dC;
    @(negedge clk);
    appValid = 0; ctlValid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 1, T0, v); chk("R1 stat0", v, 0);
    rd(1, 1, T1, v); chk("R1 stat1", v, 0);
    chk("R1 irqs", {30'd0, irqToCtl, irqToApp}, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(0, 1, S0, 32'h5);
    rd(1, 1, T0, v); chk("R2 set", v, 32'h5);
    wr(0, 1, S0, 32'h2);
    rd(1, 1, T0, v); chk("R2 keep zeros", v, 32'h7);
    chk("R4 irq high", {30'd0, irqToCtl, irqToApp}, 32'h2);
    wr(1, 1, C0, 32'h4);
    rd(0, 1, T0, v); chk("R3 clear", v, 32'h3);
    wr(1, 1, C0, 32'h3);
    rd(0, 1, T0, v); chk("R3 clear all", v, 0);
    chk("R4 irq low", {31'd0, irqToCtl}, 0);
  endtask

  task automatic t_top_bit();
    logic [31:0] v;
    wr(1, 1, S1, 32'hFFFF_FFFF);
    rd(0, 1, T1, v); chk("R5 set ignores bit31", v, 32'h7FFF_FFFF);
    chk("R4 irqToApp", {31'd0, irqToApp}, 1);
    wr(0, 1, C1, 32'hFFFF_FFFF);
    rd(0, 1, T1, v); chk("R3 clear 31 slots", v, 0);
  endtask

  task automatic t_nonsecure();
    logic [31:0] v;
    wr(0, 0, S0, 32'h1);
    rd(0, 1, T0, v); chk("R6 ns write flags only", v, 32'h8000_0000);
    chk("R6 irqToCtl", {31'd0, irqToCtl}, 1);
    rd(1, 0, T0, v); chk("R6 ns read zero", v, 0);
    rd(1, 0, T1, v); chk("R6 ns read zero ch1", v, 0);
    rd(0, 1, T1, v); chk("R6 ns read flags ch1", v, 32'h8000_0000);
    wr(0, 1, C0, 32'h7FFF_FFFF);
    rd(0, 1, T0, v); chk("R7 low clear keeps flag", v, 32'h8000_0000);
    wr(0, 1, C0, 32'h8000_0000);
    rd(0, 1, T0, v); chk("R7 flag cleared", v, 0);
    wr(1, 1, C1, 32'h8000_0000);
    rd(1, 1, T1, v); chk("R7 flag cleared ch1", v, 0);
  endtask

  task automatic t_views();
    logic [31:0] v;
    wr(0, 1, S0, 32'h10);
    rd(0, 1, S0, v); chk("R8 set view reads 0", v, 0);
    rd(0, 1, C0, v); chk("R8 clear view reads 0", v, 0);
    rd(0, 1, 12'h204, v); chk("R8 unmapped reads 0", v, 0);
    wr(0, 1, T0, 32'hFF);
    wr(1, 1, 12'h20C, 32'hFF);
    rd(0, 1, T0, v); chk("R8 writes ignored", v, 32'h10);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(1, 1, S0, 32'h8);
    both(C0, 32'h8, S0, 32'h8);
    rd(0, 1, T0, v); chk("R9 set wins", v, 32'h18);
    both(S1, 32'h1, S1, 32'h4000_0000);
    rd(0, 1, T1, v); chk("R10 both ports set", v, 32'h4000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_set_clear();
    t_top_bit();
    t_nonsecure();
    t_views();
    t_collide();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule